// File: doc/BRIEF.md
# Dual-Direction AES Column Mixer

This block applies the AES column-mixing step, or its inverse, to a full 128-bit cipher state in one combinational pass. The state holds four 32-bit columns. Each column is multiplied in GF(2^8) by a fixed circulant matrix. A single direction input chooses the forward matrix, used for encryption, or the inverse matrix, used for decryption. The same choice applies to all four columns. All 128 output bits settle together, so a round datapath can put the block between its substitution/row-rotation logic and its key-addition logic without adding a cycle.

Inside the block the two directions share hardware. The forward byte is built from one doubling of the sum of two neighbouring bytes, plus the column-wide XOR sum and the byte itself. The inverse byte is that forward byte plus two correction terms: eight times the column sum, and four times the sum of the byte and the byte two rows away. The doublings made for the forward path feed the correction terms, so there is no second array of constant multipliers.

Top module: `column_mixer`

## Requirements
- R1: With `inverse` = 0, each output column byte r equals {02}·a[r] ^ {03}·a[r+1] ^ a[r+2] ^ a[r+3] (row indices mod 4), with GF(2^8) products reduced by x^8+x^4+x^3+x+1. Byte k of the state sits at bits [127-8k -: 8], and column c holds bytes 4c..4c+3 with row 0 first. Example: column db 13 53 45 maps to 8e 4d a1 bc.
- R2: With `inverse` = 1, each output column byte r equals {0e}·a[r] ^ {0b}·a[r+1] ^ {0d}·a[r+2] ^ {09}·a[r+3]. Example: column 8e 4d a1 bc maps to db 13 53 45.
- R3: Doubling a byte whose bit 7 is set shifts it left and XORs in 0x1b. For example, a lone 0x80 in row 0 of a column gives 1b 80 80 9b in forward mode.
- R4: Each column's output depends only on that column's input bytes. A nonzero byte changes no other column's output.
- R5: In both directions, the XOR of the four output bytes of a column equals the XOR of its four input bytes.
- R6: A column whose four bytes are all equal comes out unchanged in both directions.
- R7: Applying the inverse direction to the forward result returns the original 128-bit state.
- R8: An all-zero state maps to all zeros in both directions.
- R9: For a column of the form (a, b, a, b), the inverse result equals the forward result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| state_in | input | 128 | State to be mixed; byte k at bits [127-8k -: 8] |
| inverse | input | 1 | 0 selects forward mixing, 1 selects inverse mixing |
| state_out | output | 128 | Mixed state, same byte layout as the input |

## Verification
The hardest case to reach from the ports is a fault in the shared correction path. Any error there leaves forward mode exact and shows up only in inverse mode. It can also stay hidden whenever a column's row-pair sums cancel. To reach it, the stimulus sweeps every value through every one of the 16 byte positions in both directions, with the other bytes at zero. Each correction term is then driven alone, and a spill into another column is visible. Random full states then go forward and back through the block, to check the round trip and the arithmetic model together. Uniform columns and (a, b, a, b) columns are built on purpose, because random data almost never produces them.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;

    localparam int BYTE_W   = 8;
    localparam int ROWS     = 4;
    localparam int COLS     = 4;
    localparam int COL_W    = BYTE_W * ROWS;
    localparam int STATE_W  = COL_W * COLS;

    // Low bits of the field polynomial x^8+x^4+x^3+x+1
    localparam logic [BYTE_W-1:0] FIELD_POLY = 8'h1b;

    typedef logic [BYTE_W-1:0] gbyte_t;
    // Element 0 sits in the most significant position
    typedef gbyte_t [0:ROWS-1] col_t;
    typedef col_t   [0:COLS-1] state_t;

    typedef enum logic {
        MIX_FWD = 1'b0,
        MIX_INV = 1'b1
    } mix_dir_e;

    // Wrap a row index onto the column
    function automatic int row_wrap(input int r);
        return r % ROWS;
    endfunction

endpackage

// File: rtl/gf_xtime.sv
module gf_xtime
    import mixcol_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = FIELD_POLY
) (
    input  gbyte_t a,
    output gbyte_t dbl
);
    // Multiply by x: shift up, fold the carried-out bit back in through the polynomial
    always_comb begin
        dbl = {a[BYTE_W-2:0], 1'b0} ^ (POLY & {BYTE_W{a[BYTE_W-1]}});
    end
endmodule

// File: rtl/mix_column.sv
module mix_column
    import mixcol_pkg::*;
(
    input  col_t     col_in,
    input  mix_dir_e dir,
    output col_t     col_out
);
    gbyte_t colsum;
    col_t   pair;       // a[r] ^ a[r+1]
    col_t   pair_dbl;   // {02}(a[r] ^ a[r+1])
    col_t   fwd_c;
    col_t   inv_c;
    gbyte_t sum_x2, sum_x4;
    gbyte_t alt_even_x2, alt_odd_x2;   // {02}(a0^a2), {02}(a1^a3)
    gbyte_t mix_even, mix_odd;         // {04}sum ^ {02}(alt)
    gbyte_t corr_even, corr_odd;       // {08}sum ^ {04}(alt)

    always_comb begin
        colsum = '0;
        for (int r = 0; r < ROWS; r++) colsum ^= col_in[r];
    end

    genvar g;
    generate
        for (g = 0; g < ROWS; g++) begin : g_pair
            assign pair[g] = col_in[g] ^ col_in[row_wrap(g + 1)];
            gf_xtime u_pair_x2 (.a(pair[g]), .dbl(pair_dbl[g]));
            // Forward byte: {02}(a_r ^ a_r+1) ^ column sum ^ a_r
            assign fwd_c[g] = pair_dbl[g] ^ colsum ^ col_in[g];
        end
    endgenerate

    // Reuse the pair doublings: (a0^a1)^(a1^a2) = a0^a2, and linearity of doubling
    assign alt_even_x2 = pair_dbl[0] ^ pair_dbl[1];
    assign alt_odd_x2  = pair_dbl[1] ^ pair_dbl[2];

    gf_xtime u_sum_x2  (.a(colsum), .dbl(sum_x2));
    gf_xtime u_sum_x4  (.a(sum_x2), .dbl(sum_x4));

    assign mix_even = sum_x4 ^ alt_even_x2;
    assign mix_odd  = sum_x4 ^ alt_odd_x2;

    gf_xtime u_corr_e (.a(mix_even), .dbl(corr_even));
    gf_xtime u_corr_o (.a(mix_odd),  .dbl(corr_odd));

    generate
        for (g = 0; g < ROWS; g++) begin : g_inv
            if ((g % 2) == 0) begin : g_even
                assign inv_c[g] = fwd_c[g] ^ corr_even;
            end else begin : g_odd
                assign inv_c[g] = fwd_c[g] ^ corr_odd;
            end
        end
    endgenerate

    assign col_out = (dir == MIX_INV) ? inv_c : fwd_c;

    always_comb begin
        // R5
        xor_sum_chk: assert ((col_out[0] ^ col_out[1] ^ col_out[2] ^ col_out[3]) == colsum);
        if (col_in[0] == col_in[1] && col_in[1] == col_in[2] && col_in[2] == col_in[3]) begin
            // R6
            uniform_fix_chk: assert (col_out == col_in);
        end
        if (col_in[0] == col_in[2] && col_in[1] == col_in[3]) begin
            // R9
            paired_col_chk: assert (inv_c == fwd_c);
        end
        if (col_in == '0) begin
            // R8
            zero_map_chk: assert (col_out == '0);
        end
    end
endmodule

// File: rtl/column_mixer.sv
module column_mixer
    import mixcol_pkg::*;
(
    input  logic [127:0] state_in,
    input  logic         inverse,
    output logic [127:0] state_out
);
    state_t   st_in;
    state_t   st_out;
    mix_dir_e dir;

    assign st_in     = state_t'(state_in);
    assign dir       = mix_dir_e'(inverse);
    assign state_out = st_out;

    genvar c;
    generate
        for (c = 0; c < COLS; c++) begin : g_col
            mix_column u_col (
                .col_in  (st_in[c]),
                .dir     (dir),
                .col_out (st_out[c])
            );
        end
    endgenerate
endmodule

// File: tb/column_mixer_tb.sv
module column_mixer_tb;
    logic         clk = 1'b0;
    logic [127:0] s_in = '0;
    logic         inv  = 1'b0;
    logic [127:0] s_out;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    column_mixer u_dut (.state_in(s_in), .inverse(inv), .state_out(s_out));

    function automatic logic [7:0] gmul(input logic [7:0] x, input logic [7:0] y);
        logic [7:0] p = '0;
        logic [7:0] a = x;
        logic [7:0] b = y;
        for (int i = 0; i < 8; i++) begin
            if (b[0]) p ^= a;
            a = a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
            b = b >> 1;
        end
        return p;
    endfunction

    function automatic logic [127:0] model(input logic [127:0] s, input bit iv);
        logic [7:0] cf [4];
        logic [127:0] o = '0;
        if (iv) begin cf[0]=8'h0e; cf[1]=8'h0b; cf[2]=8'h0d; cf[3]=8'h09; end
        else    begin cf[0]=8'h02; cf[1]=8'h03; cf[2]=8'h01; cf[3]=8'h01; end
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                logic [7:0] acc = '0;
                for (int k = 0; k < 4; k++)
                    acc ^= gmul(cf[(k - r + 4) % 4], s[127 - 8*(4*c + k) -: 8]);
                o[127 - 8*(4*c + r) -: 8] = acc;
            end
        return o;
    endfunction

    task automatic apply(input logic [127:0] s, input bit iv);
        @(posedge clk);
        s_in = s;
        inv  = iv;
        @(negedge clk);
    endtask

    task automatic chk(input logic [127:0] got, input logic [127:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [31:0] colxor(input logic [127:0] s);
        logic [31:0] x = '0;
        for (int c = 0; c < 4; c++)
            x[31 - 8*c -: 8] = s[127-32*c -: 8] ^ s[119-32*c -: 8] ^ s[111-32*c -: 8] ^ s[103-32*c -: 8];
        return x;
    endfunction

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [127:0] r, f, b;
        // R8: zero state in both directions
        apply('0, 0); chk(s_out, '0, "R8 fwd zero");
        apply('0, 1); chk(s_out, '0, "R8 inv zero");

        // R1 / R2 known column in every position
        for (int c = 0; c < 4; c++) begin
            apply(128'hdb135345 << (96 - 32*c), 0);
            chk(s_out, 128'h8e4da1bc << (96 - 32*c), "R1 known column");
            apply(128'h8e4da1bc << (96 - 32*c), 1);
            chk(s_out, 128'hdb135345 << (96 - 32*c), "R2 known column");
        end

        // R3: reduction on a lone 0x80
        apply({8'h80, 120'h0}, 0);
        chk(s_out, {32'h1b80809b, 96'h0}, "R3 xtime reduction");

        // R4 / R1 / R2: every value in every byte position, both directions
        for (int p = 0; p < 16; p++)
            for (int v = 0; v < 256; v++)
                for (int d = 0; d < 2; d++) begin
                    r = 128'(v) << (120 - 8*p);
                    apply(r, bit'(d));
                    chk(s_out, model(r, bit'(d)), d ? "R2 R4 single byte" : "R1 R4 single byte");
                end

        // R6: uniform columns
        for (int v = 0; v < 256; v++)
            for (int d = 0; d < 2; d++) begin
                r = {16{8'(v)}};
                apply(r, bit'(d));
                chk(s_out, r, "R6 uniform column");
            end

        // R9: (a,b,a,b) columns
        for (int i = 0; i < 200; i++) begin
            logic [15:0] ab;
            ab = 16'($urandom);
            r = {8{ab}};
            apply(r, 0); f = s_out;
            apply(r, 1);
            chk(s_out, f, "R9 paired column");
        end

        // R7 / R5 / R1 / R2: random full states
        for (int i = 0; i < 400; i++) begin
            r = {$urandom, $urandom, $urandom, $urandom};
            apply(r, 0); f = s_out;
            chk(f, model(r, 0), "R1 random");
            chk({96'h0, colxor(f)}, {96'h0, colxor(r)}, "R5 fwd column sum");
            apply(f, 1); b = s_out;
            chk(b, r, "R7 round trip");
            apply(r, 1);
            chk(s_out, model(r, 1), "R2 random");
            chk({96'h0, colxor(s_out)}, {96'h0, colxor(r)}, "R5 inv column sum");
        end
        finish_run();
    end
endmodule